// File: doc/BRIEF.md
# Flagged-Residue Modular Adder with Run-Time Modulus

This block adds two residues modulo m = 2^N − d, where the offset d is held in a small configuration register that can be rewritten at run time. Residues travel in a flagged form: an N-bit magnitude together with a one-bit flag. The value a pair stands for is the magnitude minus d if the flag is set, or the plain magnitude if it is clear, taken modulo m. The adder never performs the final "subtract the modulus if too large" step. When the sum still owes a subtraction of d, it leaves the flag set instead, and the next operation that consumes the result settles the debt.

The datapath from the operand inputs to the result is purely combinational. A three-input carry-save row merges the two magnitudes with an offset term chosen by the two input flags. One N-bit carry-propagate adder, whose topology is a parameter, then resolves the row. A few gates derive the result flag from the carries that land above bit N−1. Because d sits in a register, one circuit serves every modulus of that width in the legal range.

Top module: `exd_mod_adder`

## Requirements
- R1: A pair (flag f, magnitude g) encodes the residue (g − f·d) mod m, with m = 2^N − d. An input is canonical when f = 0 with g < m, or when f = 1 with d ≤ g ≤ 2^N − 1.
- R2: For canonical inputs, the decoded result equals (X + Y) mod m in the same cycle as the inputs, for every legal d.
- R3: Let T = x_mag + y_mag + F, where F = +d when both input flags are 0, F = 0 when exactly one flag is 1, and F = −d when both are 1. Then s_flag = 1 exactly when T < 2^N, and s_mag = T mod 2^N.
- R4: For canonical inputs the result is canonical in the sense of R1.
- R5: After reset, d equals the parameter DELTA_RESET (default 3).
- R6: A rising clock edge with cfg_we = 1 and a nonzero cfg_delta loads cfg_delta into d. Results use the new d from just after that edge, and use the old d before it.
- R7: A write with cfg_delta = 0 is ignored, and d keeps its previous nonzero value.
- R8: With cfg_we = 0, d holds its value across clock edges.
- R9: With N = 5 and d = 3, the inputs (0,28) and (0,3) give the result (0,2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the offset register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the offset register |
| cfg_delta | input | N-1 | New offset d; zero is rejected |
| x_flag | input | 1 | Flag of operand X |
| x_mag | input | N | Magnitude of operand X |
| y_flag | input | 1 | Flag of operand Y |
| y_mag | input | N | Magnitude of operand Y |
| s_flag | output | 1 | Flag of the sum (set: d still owed) |
| s_mag | output | N | Magnitude of the sum |

## Verification
The sum flag and magnitude are combinational, so they are due in the same cycle the operands change. The bench drives operands at the falling edge and samples one time unit later, well clear of any rising edge. An offset write takes effect one register stage later. The bench therefore samples the result once just before the capturing rising edge, where the old d must still apply, and once just after it, where the new d must apply. Five-bit widths are swept exhaustively over all canonical pairs for two offsets, while an eight-bit instance is checked on random canonical pairs for two further offsets.

// File: rtl/exd_pkg.sv
package exd_pkg;
   // carry-propagate adder topology choice
   typedef enum logic [0:0] {
      CPA_RIPPLE = 1'b0,
      CPA_NATIVE = 1'b1
   } cpa_kind_e;
endpackage

// File: rtl/exd_delta_reg.sv
module exd_delta_reg #(
   parameter int DW      = 4,
   parameter int DEFAULT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] delta_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         delta_q <= DW'(DEFAULT);
      else if (we && (wdata != '0))
         delta_q <= wdata;
   end

   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata != '0) |=> (delta_q == $past(wdata)));
   p_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == '0) |=> $stable(delta_q));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |=> $stable(delta_q));
   p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      delta_q != '0);
endmodule

// File: rtl/exd_offset_gen.sv
module exd_offset_gen #(
   parameter int N = 5
) (
   input  logic         fa,
   input  logic         fb,
   input  logic [N-2:0] delta,
   output logic [N-1:0] off_low,
   output logic         off_sign,
   output logic         off_cin
);
   logic [N-1:0] d_ext;
   assign d_ext = {1'b0, delta};

   always_comb begin
      off_low  = '0;
      off_sign = 1'b0;
      off_cin  = 1'b0;
      if (!fa && !fb) begin
         off_low = d_ext;           // +d
      end else if (fa && fb) begin
         off_low  = ~d_ext;         // -d as ones' complement, +1 via carry-in
         off_sign = 1'b1;
         off_cin  = 1'b1;
      end
   end
endmodule

// File: rtl/exd_csa.sv
module exd_csa #(
   parameter int N = 5
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic [N-1:0] c,
   output logic [N-1:0] sum,
   output logic [N-1:0] cry   // cry[i] carries weight 2^(i+1)
);
   for (genvar i = 0; i < N; i++) begin : g_fa
      assign sum[i] = a[i] ^ b[i] ^ c[i];
      assign cry[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
   end
endmodule

// File: rtl/exd_cpa.sv
module exd_cpa
   import exd_pkg::*;
#(
   parameter int        N    = 5,
   parameter cpa_kind_e KIND = CPA_RIPPLE
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout
);
   if (KIND == CPA_RIPPLE) begin : g_ripple
      logic [N:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign sum[i]   = a[i] ^ b[i] ^ c[i];
         assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
      end
      assign cout = c[N];
   end else begin : g_native
      logic [N:0] full;
      assign full = {1'b0, a} + {1'b0, b} + (N+1)'(cin);
      assign sum  = full[N-1:0];
      assign cout = full[N];
   end
endmodule

// File: rtl/exd_mod_adder.sv
module exd_mod_adder
   import exd_pkg::*;
#(
   parameter int        N           = 5,
   parameter int        DELTA_RESET = 3,
   parameter cpa_kind_e CPA_KIND    = CPA_RIPPLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_we,
   input  logic [N-2:0] cfg_delta,
   input  logic         x_flag,
   input  logic [N-1:0] x_mag,
   input  logic         y_flag,
   input  logic [N-1:0] y_mag,
   output logic         s_flag,
   output logic [N-1:0] s_mag
);
   localparam int DW = N - 1;

   if (N < 3) begin : g_bad_width
      $error("exd_mod_adder: N must be at least 3");
   end
   if (DELTA_RESET <= 0 || DELTA_RESET >= (1 << DW)) begin : g_bad_default
      $error("exd_mod_adder: DELTA_RESET outside (0, 2^(N-1))");
   end

   logic [DW-1:0] delta;
   logic [N-1:0]  off_low;
   logic          off_sign, off_cin;
   logic [N-1:0]  row_sum, row_cry;
   logic          cpa_cout;

   exd_delta_reg #(.DW(DW), .DEFAULT(DELTA_RESET)) u_dreg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_delta), .delta_q(delta)
   );

   exd_offset_gen #(.N(N)) u_off (
      .fa(x_flag), .fb(y_flag), .delta(delta),
      .off_low(off_low), .off_sign(off_sign), .off_cin(off_cin)
   );

   exd_csa #(.N(N)) u_csa (
      .a(x_mag), .b(y_mag), .c(off_low), .sum(row_sum), .cry(row_cry)
   );

   exd_cpa #(.N(N), .KIND(CPA_KIND)) u_cpa (
      .a(row_sum), .b({row_cry[N-2:0], off_cin}), .cin(1'b0),
      .sum(s_mag), .cout(cpa_cout)
   );

   // weight-2^N contribution is cout + top carry - sign, always 0 or 1;
   // flag stays set (d owed) when that contribution is 0
   assign s_flag = off_sign ? ~(cpa_cout & row_cry[N-1])
                            : ~(cpa_cout | row_cry[N-1]);

   // canonical-input checks on the result encoding
   logic [N:0] modv;
   logic       x_ok, y_ok;
   assign modv = (N+1)'(1 << N) - (N+1)'(delta);
   assign x_ok = x_flag ? (x_mag >= N'(delta)) : ({1'b0, x_mag} < modv);
   assign y_ok = y_flag ? (y_mag >= N'(delta)) : ({1'b0, y_mag} < modv);

   p_canon_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ok && y_ok && !s_flag) |-> ({1'b0, s_mag} < modv));
   p_canon_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ok && y_ok && s_flag) |-> (s_mag >= N'(delta)));
endmodule

// File: tb/exd_mod_adder_tb.sv
module exd_mod_adder_tb;
   import exd_pkg::*;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic       we5 = 0, af5 = 0, bf5 = 0, sf5;
   logic [3:0] wd5 = 0;
   logic [4:0] am5 = 0, bm5 = 0, sm5;
   logic       we8 = 0, af8 = 0, bf8 = 0, sf8;
   logic [6:0] wd8 = 0;
   logic [7:0] am8 = 0, bm8 = 0, sm8;

   int checks = 0, errors = 0;
   int d5 = 3, d8 = 3;
   bit done = 0;

   exd_mod_adder #(.N(5), .DELTA_RESET(3), .CPA_KIND(CPA_RIPPLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we5), .cfg_delta(wd5),
      .x_flag(af5), .x_mag(am5), .y_flag(bf5), .y_mag(bm5),
      .s_flag(sf5), .s_mag(sm5));

   exd_mod_adder #(.N(8), .DELTA_RESET(3), .CPA_KIND(CPA_NATIVE)) u_dut_w8 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we8), .cfg_delta(wd8),
      .x_flag(af8), .x_mag(am8), .y_flag(bf8), .y_mag(bm8),
      .s_flag(sf8), .s_mag(sm8));

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int decode(int f, int g, int d, int n);
      int m = (1 << n) - d;
      int v = g - (f != 0 ? d : 0);
      v = v % m;
      if (v < 0) v += m;
      return v;
   endfunction

   function automatic int is_canon(int f, int g, int d, int n);
      int m = (1 << n) - d;
      if (f != 0) return (g >= d && g < (1 << n)) ? 1 : 0;
      return (g < m) ? 1 : 0;
   endfunction

   task automatic enc(int k, int d, int n, output int f, output int g);
      int m = (1 << n) - d;
      if (k < m) begin f = 0; g = k; end
      else begin f = 1; g = d + (k - m); end
   endtask

   // drive both operands at the falling edge, sample 1 unit later, check R2/R3/R4
   task automatic run_pair(bit w8, int fa, int ga, int fb, int gb);
      int n = w8 ? 8 : 5;
      int d = w8 ? d8 : d5;
      int m = (1 << n) - d;
      int off, t, gf, gg;
      @(negedge clk);
      if (w8) begin af8 = fa[0]; am8 = ga[7:0]; bf8 = fb[0]; bm8 = gb[7:0]; end
      else    begin af5 = fa[0]; am5 = ga[4:0]; bf5 = fb[0]; bm5 = gb[4:0]; end
      #1;
      gf = w8 ? int'(sf8) : int'(sf5);
      gg = w8 ? int'(sm8) : int'(sm5);
      off = (fa == 0 && fb == 0) ? d : ((fa != 0 && fb != 0) ? -d : 0);
      t = ga + gb + off;
      chk("R3 flag", gf, (t < (1 << n)) ? 1 : 0);
      chk("R3 mag", gg, t % (1 << n));
      chk("R2 sum", decode(gf, gg, d, n),
          (decode(fa, ga, d, n) + decode(fb, gb, d, n)) % m);
      chk("R4 canonical", is_canon(gf, gg, d, n), 1);
   endtask

   task automatic set_delta(bit w8, int v);
      @(negedge clk);
      if (w8) begin we8 = 1; wd8 = v[6:0]; end
      else    begin we5 = 1; wd5 = v[3:0]; end
      @(posedge clk); #1;
      we8 = 0; we5 = 0;
      if (v != 0) begin if (w8) d8 = v; else d5 = v; end
   endtask

   task automatic t_reset_r5;
      run_pair(0, 0, 0, 0, 0);
      chk("R5 reset delta (5b mag)", sm5, 3);
      chk("R5 reset delta (5b flag)", sf5, 1);
      run_pair(1, 0, 0, 0, 0);
      chk("R5 reset delta (8b mag)", sm8, 3);
   endtask

   task automatic t_example_r9;
      run_pair(0, 0, 28, 0, 3);
      chk("R9 example flag", sf5, 0);
      chk("R9 example mag", sm5, 2);
   endtask

   task automatic t_sweep_r1(int d);
      int m, fa, ga, fb, gb;
      set_delta(0, d);
      m = 32 - d;
      for (int i = 0; i < 2*m; i++)
         for (int j = 0; j < 2*m; j++) begin
            enc(i, d, 5, fa, ga);
            enc(j, d, 5, fb, gb);
            run_pair(0, fa, ga, fb, gb);   // R1 encodings, all pairs
         end
   endtask

   task automatic t_random8(int d, int count);
      int m, fa, ga, fb, gb;
      set_delta(1, d);
      m = 256 - d;
      for (int i = 0; i < count; i++) begin
         enc(int'($urandom_range(2*m - 1)), d, 8, fa, ga);
         enc(int'($urandom_range(2*m - 1)), d, 8, fb, gb);
         run_pair(1, fa, ga, fb, gb);
      end
      run_pair(1, 1, 255, 1, 255);       // largest magnitudes, both flagged
      run_pair(1, 0, m-1, 0, m-1);       // largest plain residues
   endtask

   task automatic t_write_timing_r6;
      set_delta(0, 3);
      @(negedge clk);
      af5 = 0; am5 = 0; bf5 = 0; bm5 = 0;
      we5 = 1; wd5 = 4'd7;
      #1;
      chk("R6 old delta before edge", sm5, 3);
      @(posedge clk); #1;
      we5 = 0; d5 = 7;
      chk("R6 new delta after edge", sm5, 7);
      chk("R6 flag after edge", sf5, 1);
   endtask

   task automatic t_zero_write_r7;
      set_delta(0, 15);
      set_delta(0, 0);
      run_pair(0, 0, 0, 0, 0);
      chk("R7 zero write ignored", sm5, 15);
      run_pair(0, 0, 16, 0, 1);          // 17 mod 17 = 0 with d=15
   endtask

   task automatic t_hold_r8;
      set_delta(0, 9);
      repeat (5) @(posedge clk);
      run_pair(0, 0, 0, 0, 0);
      chk("R8 delta held", sm5, 9);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset_r5();
      t_example_r9();
      t_write_timing_r6();
      t_zero_write_r7();
      t_hold_r8();
      t_sweep_r1(3);
      t_sweep_r1(15);
      t_random8(125, 1500);
      t_random8(65, 1500);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule